// File: doc/BRIEF.md
# Hierarchical Digest Chain Checker

This block attests a code section or a configuration image before it is trusted or loaded. Reference digests sit in ordinary memory in two tiers. A second-tier table is split into sections of entries. A first-tier table holds one digest for each of those sections. Only the digest of the first-tier table, the anchor, comes from secure read-only storage, and it arrives on a dedicated input.

A request names a section, an entry, and the target's base address and length in words. The checker then climbs three links of a chain. First it has the target hashed and compares the result with the chosen second-tier entry. Next it has the whole second-tier section hashed and compares that with the section's first-tier entry. Last it has the first-tier table hashed and compares that with the anchor.

Hashing is done by an external engine through a request/response handshake. Every comparison reads the reference one memory word per step. The first mismatch ends the run and reports the link that broke. For a configuration bitstream, the caller holds back loading until a pass is seen.

Top module: `digest_chain_checker`

## Requirements
- R1: After reset, busy_o, done_o, pass_o, fail_o and hreq_o are all 0 and fail_code_o is 0.
- R2: A start_i sampled while idle gives a one-cycle hreq_o in the following cycle. That request carries hbase_o = tgt_base_i and hlen_o = tgt_len_i, and fail_code_o is cleared to 0.
- R3: Link 1 compares digest word k (bits [k*WORD_W +: WORD_W]) with the memory word at L2_BASE + (sec*N_ENT + idx)*WPD + k, where WPD = DIGEST_W/WORD_W. A mismatch in any word ends the run with fail_o and fail_code_o = 1.
- R4: Link 2 requests a hash with base L2_BASE + sec*N_ENT*WPD and length N_ENT*WPD. It compares the result word by word with L1_BASE + sec*WPD + k. A mismatch gives fail_code_o = 2.
- R5: Link 3 requests a hash with base L1_BASE and length N_SEC*WPD. It compares the result with root_i word by word, without reading memory. A mismatch gives fail_code_o = 3.
- R6: When all three links match, pass_o and done_o are high together for exactly one cycle, fail_o stays 0 and fail_code_o is 0.
- R7: Each link issues exactly one hash request, and links run in order. A failure at link n means exactly n requests were made in that run.
- R8: hdone_i has no effect unless the checker is waiting for a hash response. This holds both while idle and during a comparison.
- R9: A start_i that arrives while busy_o is high is ignored. The run in progress completes with its original section, entry and target.
- R10: fail_code_o holds its value after done_o until the next accepted start.
- R11: hreq_o is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an attestation run |
| sec_i | input | SEC_W | Second-tier section to use |
| idx_i | input | IDX_W | Entry within the section |
| tgt_base_i | input | ADDR_W | First word of the target |
| tgt_len_i | input | LEN_W | Target length in words |
| hreq_o | output | 1 | Hash request pulse |
| hbase_o | output | ADDR_W | Base address of the region to hash |
| hlen_o | output | LEN_W | Length of the region in words |
| hdone_i | input | 1 | Hash response valid |
| hdigest_i | input | DIGEST_W | Digest returned by the engine |
| mem_rd_o | output | 1 | Table memory read strobe, data one cycle later |
| mem_addr_o | output | ADDR_W | Table memory word address |
| mem_rdata_i | input | WORD_W | Table memory read data |
| root_i | input | DIGEST_W | Anchor digest from secure storage |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run strobe |
| pass_o | output | 1 | Whole chain matched (with done_o) |
| fail_o | output | 1 | A link mismatched (with done_o) |
| fail_code_o | output | 2 | Link that failed: 1, 2 or 3; 0 otherwise |

## Verification
On every cycle, the embedded assertions check these things. The hash request is a single-cycle pulse. Pass and fail are exclusive and only appear with a one-cycle done. A failure always carries a nonzero link code, and a pass carries zero. A response that arrives outside the wait state leaves the captured digest untouched, and a start while busy leaves the latched selection unchanged. The bench scenarios cover what the assertions cannot see: the request addresses and lengths for each link, that a corrupted word at any position of any reference stops the run at exactly the right link with the right request count, and that stray responses and late starts leave the verdict as the requirements predict.

// File: rtl/chain_pkg.sv
package chain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HREQ,
        ST_HWAIT,
        ST_CMP_RD,
        ST_CMP_CHK,
        ST_FINISH
    } seq_st_e;

    localparam logic [1:0] LINK_NONE   = 2'd0;
    localparam logic [1:0] LINK_TARGET = 2'd1;
    localparam logic [1:0] LINK_SECT   = 2'd2;
    localparam logic [1:0] LINK_ANCHOR = 2'd3;

endpackage

// File: rtl/chain_addr_gen.sv
module chain_addr_gen
    import chain_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int LEN_W   = 16,
    parameter int WPD     = 8,
    parameter int N_SEC   = 4,
    parameter int N_ENT   = 8,
    parameter int SEC_W   = 2,
    parameter int IDX_W   = 3,
    parameter int L2_BASE = 256,
    parameter int L1_BASE = 64
) (
    input  logic [1:0]        link_i,
    input  logic [SEC_W-1:0]  sec_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [ADDR_W-1:0] tbase_i,
    input  logic [LEN_W-1:0]  tlen_i,
    output logic [ADDR_W-1:0] hbase_o,
    output logic [LEN_W-1:0]  hlen_o,
    output logic [ADDR_W-1:0] ref_base_o,
    output logic              use_rom_o
);
    localparam int SECT_WORDS = N_ENT * WPD;
    localparam int L1_WORDS   = N_SEC * WPD;

    logic [31:0] ent_off;
    logic [31:0] sect_off;
    logic [31:0] l1_off;

    always_comb begin
        ent_off  = (32'(sec_i) * 32'(N_ENT) + 32'(idx_i)) * 32'(WPD);
        sect_off = 32'(sec_i) * 32'(SECT_WORDS);
        l1_off   = 32'(sec_i) * 32'(WPD);
    end

    always_comb begin
        hbase_o    = '0;
        hlen_o     = '0;
        ref_base_o = '0;
        use_rom_o  = 1'b0;
        unique case (link_i)
            LINK_TARGET: begin
                hbase_o    = tbase_i;
                hlen_o     = tlen_i;
                ref_base_o = ADDR_W'(32'(L2_BASE) + ent_off);
            end
            LINK_SECT: begin
                hbase_o    = ADDR_W'(32'(L2_BASE) + sect_off);
                hlen_o     = LEN_W'(SECT_WORDS);
                ref_base_o = ADDR_W'(32'(L1_BASE) + l1_off);
            end
            LINK_ANCHOR: begin
                hbase_o    = ADDR_W'(L1_BASE);
                hlen_o     = LEN_W'(L1_WORDS);
                use_rom_o  = 1'b1;
            end
            default: begin
                hbase_o    = '0;
            end
        endcase
    end

endmodule

// File: rtl/chain_word_cmp.sv
module chain_word_cmp #(
    parameter int DIGEST_W = 256,
    parameter int WORD_W   = 32,
    parameter int WPD      = 8,
    parameter int WIDX_W   = 3
) (
    input  logic [DIGEST_W-1:0] digest_i,
    input  logic [DIGEST_W-1:0] root_i,
    input  logic [WORD_W-1:0]   mem_word_i,
    input  logic [WIDX_W-1:0]   widx_i,
    input  logic                use_rom_i,
    output logic                match_o
);
    logic [WORD_W-1:0] dig_word;
    logic [WORD_W-1:0] rom_word;
    logic [WORD_W-1:0] ref_word;

    always_comb begin
        dig_word = '0;
        rom_word = '0;
        for (int i = 0; i < WPD; i++) begin
            if (widx_i == WIDX_W'(i)) begin
                dig_word = digest_i[i*WORD_W +: WORD_W];
                rom_word = root_i[i*WORD_W +: WORD_W];
            end
        end
        ref_word = use_rom_i ? rom_word : mem_word_i;
        match_o  = (dig_word == ref_word);
    end

endmodule

// File: rtl/digest_chain_checker.sv
module digest_chain_checker
    import chain_pkg::*;
#(
    parameter int DIGEST_W = 256,
    parameter int WORD_W   = 32,
    parameter int ADDR_W   = 16,
    parameter int LEN_W    = 16,
    parameter int N_SEC    = 4,
    parameter int N_ENT    = 8,
    parameter int L2_BASE  = 256,
    parameter int L1_BASE  = 64,
    localparam int WPD     = DIGEST_W / WORD_W,
    localparam int SEC_W   = (N_SEC > 1) ? $clog2(N_SEC) : 1,
    localparam int IDX_W   = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    localparam int WIDX_W  = (WPD > 1) ? $clog2(WPD) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [SEC_W-1:0]    sec_i,
    input  logic [IDX_W-1:0]    idx_i,
    input  logic [ADDR_W-1:0]   tgt_base_i,
    input  logic [LEN_W-1:0]    tgt_len_i,
    output logic                hreq_o,
    output logic [ADDR_W-1:0]   hbase_o,
    output logic [LEN_W-1:0]    hlen_o,
    input  logic                hdone_i,
    input  logic [DIGEST_W-1:0] hdigest_i,
    output logic                mem_rd_o,
    output logic [ADDR_W-1:0]   mem_addr_o,
    input  logic [WORD_W-1:0]   mem_rdata_i,
    input  logic [DIGEST_W-1:0] root_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                pass_o,
    output logic                fail_o,
    output logic [1:0]          fail_code_o
);
    localparam logic [WIDX_W-1:0] LAST_W = WIDX_W'(WPD - 1);

    typedef struct packed {
        seq_st_e             st;
        logic [1:0]          link;
        logic [WIDX_W-1:0]   widx;
        logic [SEC_W-1:0]    sec;
        logic [IDX_W-1:0]    idx;
        logic [ADDR_W-1:0]   tbase;
        logic [LEN_W-1:0]    tlen;
        logic [DIGEST_W-1:0] dig;
        logic                ok;
        logic [1:0]          code;
    } regs_t;

    regs_t r_d, r_q;

    logic [ADDR_W-1:0] ref_base;
    logic              use_rom;
    logic              word_match;

    chain_addr_gen #(
        .ADDR_W (ADDR_W), .LEN_W (LEN_W), .WPD (WPD),
        .N_SEC (N_SEC), .N_ENT (N_ENT), .SEC_W (SEC_W), .IDX_W (IDX_W),
        .L2_BASE (L2_BASE), .L1_BASE (L1_BASE)
    ) u_addr (
        .link_i     (r_q.link),
        .sec_i      (r_q.sec),
        .idx_i      (r_q.idx),
        .tbase_i    (r_q.tbase),
        .tlen_i     (r_q.tlen),
        .hbase_o    (hbase_o),
        .hlen_o     (hlen_o),
        .ref_base_o (ref_base),
        .use_rom_o  (use_rom)
    );

    chain_word_cmp #(
        .DIGEST_W (DIGEST_W), .WORD_W (WORD_W), .WPD (WPD), .WIDX_W (WIDX_W)
    ) u_cmp (
        .digest_i   (r_q.dig),
        .root_i     (root_i),
        .mem_word_i (mem_rdata_i),
        .widx_i     (r_q.widx),
        .use_rom_i  (use_rom),
        .match_o    (word_match)
    );

    // next-state computation
    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st    = ST_HREQ;
                    r_d.link  = LINK_TARGET;
                    r_d.widx  = '0;
                    r_d.sec   = sec_i;
                    r_d.idx   = idx_i;
                    r_d.tbase = tgt_base_i;
                    r_d.tlen  = tgt_len_i;
                    r_d.ok    = 1'b0;
                    r_d.code  = LINK_NONE;
                end
            end
            ST_HREQ: begin
                r_d.st = ST_HWAIT;
            end
            ST_HWAIT: begin
                if (hdone_i) begin
                    r_d.dig  = hdigest_i;
                    r_d.widx = '0;
                    r_d.st   = ST_CMP_RD;
                end
            end
            ST_CMP_RD: begin
                r_d.st = ST_CMP_CHK;
            end
            ST_CMP_CHK: begin
                if (!word_match) begin
                    r_d.st   = ST_FINISH;
                    r_d.ok   = 1'b0;
                    r_d.code = r_q.link;
                end else if (r_q.widx == LAST_W) begin
                    if (r_q.link == LINK_ANCHOR) begin
                        r_d.st = ST_FINISH;
                        r_d.ok = 1'b1;
                    end else begin
                        r_d.link = r_q.link + 2'd1;
                        r_d.st   = ST_HREQ;
                    end
                end else begin
                    r_d.widx = r_q.widx + 1'b1;
                    r_d.st   = ST_CMP_RD;
                end
            end
            ST_FINISH: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign hreq_o      = (r_q.st == ST_HREQ);
    assign mem_rd_o    = (r_q.st == ST_CMP_RD) && !use_rom;
    assign mem_addr_o  = ref_base + ADDR_W'(r_q.widx);
    assign busy_o      = (r_q.st != ST_IDLE);
    assign done_o      = (r_q.st == ST_FINISH);
    assign pass_o      = done_o && r_q.ok;
    assign fail_o      = done_o && !r_q.ok;
    assign fail_code_o = r_q.code;

    // ---------------- assertions ----------------
    assert_hreq_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hreq_o |=> !hreq_o);

    assert_pass_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |-> (done_o && !fail_o));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_fail_has_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> (fail_code_o != LINK_NONE));

    assert_pass_code_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |-> (fail_code_o == LINK_NONE));

    assert_code_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(fail_code_o));

    assert_stray_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_HWAIT && hdone_i) |=> $stable(r_q.dig));

    assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(r_q.sec) && $stable(r_q.idx) && $stable(r_q.tbase)));

    assert_read_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o || hreq_o) |-> busy_o);

endmodule

// File: tb/digest_chain_checker_tb.sv
module digest_chain_checker_tb;
    localparam int DW = 32, WW = 8, AW = 8, LW = 8;
    localparam int NS = 2, NE = 2, L2B = 16, L1B = 64, WPD = DW / WW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [0:0]    sec_i = '0;
    logic [0:0]    idx_i = '0;
    logic [AW-1:0] tgt_base_i = '0;
    logic [LW-1:0] tgt_len_i = '0;
    logic          hreq_o;
    logic [AW-1:0] hbase_o;
    logic [LW-1:0] hlen_o;
    logic          hdone_i = 1'b0;
    logic [DW-1:0] hdigest_i = '0;
    logic          mem_rd_o;
    logic [AW-1:0] mem_addr_o;
    logic [WW-1:0] mem_rdata_i = '0;
    logic [DW-1:0] root_i = '0;
    logic          busy_o, done_o, pass_o, fail_o;
    logic [1:0]    fail_code_o;

    always #2.5 clk = ~clk;

    digest_chain_checker #(
        .DIGEST_W (DW), .WORD_W (WW), .ADDR_W (AW), .LEN_W (LW),
        .N_SEC (NS), .N_ENT (NE), .L2_BASE (L2B), .L1_BASE (L1B)
    ) u_dut (.*);

    logic [7:0] mem [256];
    int n_chk = 0, n_bad = 0;
    int req_total = 0;
    int req_base [1024];
    int req_len  [1024];
    int stray_token = 0;
    bit extra_mode = 1'b0;

    function automatic logic [31:0] mh(int b, int l);
        logic [31:0] x;
        x = 32'h9e3779b9 ^ 32'(b << 8) ^ 32'(l);
        for (int i = 0; i < l; i++) begin
            x = {x[26:0], x[31:27]} ^ {24'h0, mem[(b + i) & 255]};
            x = x + 32'h7f4a7c15;
        end
        return x;
    endfunction

    // hash engine and table memory model, all driven at negedge
    initial begin : engine
        int pend, pb, pl, seen;
        bit garbage;
        pend = 0; pb = 0; pl = 0; seen = 0; garbage = 1'b0;
        forever begin
            @(negedge clk);
            hdone_i = 1'b0;
            if (mem_rd_o) mem_rdata_i = mem[mem_addr_o];
            if (garbage) begin
                garbage = 1'b0;
                hdone_i = 1'b1;
                hdigest_i = ~hdigest_i;
            end
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    hdone_i = 1'b1;
                    hdigest_i = mh(pb, pl);
                    garbage = extra_mode;
                end
            end
            if (stray_token != seen) begin
                seen = stray_token;
                hdone_i = 1'b1;
                hdigest_i = 32'hdead_beef;
            end
            if (hreq_o) begin
                req_base[req_total & 1023] = int'(hbase_o);
                req_len[req_total & 1023]  = int'(hlen_o);
                req_total++;
                pb = int'(hbase_o); pl = int'(hlen_o); pend = 3;
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
        $finish;
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int l2_ent(int s, int e);
        return L2B + (s * NE + e) * WPD;
    endfunction

    function automatic int tgt_b(int s, int e);
        return 128 + (s * NE + e) * 8;
    endfunction

    function automatic int tgt_l(int s, int e);
        return 5 + s + e;
    endfunction

    task automatic build_tables();
        logic [31:0] h;
        for (int s = 0; s < NS; s++)
            for (int e = 0; e < NE; e++) begin
                h = mh(tgt_b(s, e), tgt_l(s, e));
                for (int k = 0; k < WPD; k++) mem[l2_ent(s, e) + k] = h[k*8 +: 8];
            end
        for (int s = 0; s < NS; s++) begin
            h = mh(L2B + s * NE * WPD, NE * WPD);
            for (int k = 0; k < WPD; k++) mem[L1B + s * WPD + k] = h[k*8 +: 8];
        end
        root_i = mh(L1B, NS * WPD);
    endtask

    // one attestation run; exp_code 0 = pass
    task automatic run(input int s, input int e, input int exp_code, input bit late_start);
        int snap, cyc, nreq;
        snap = req_total;
        @(negedge clk);
        sec_i = 1'(s); idx_i = 1'(e);
        tgt_base_i = AW'(tgt_b(s, e)); tgt_len_i = LW'(tgt_l(s, e));
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 hreq after start", longint'(hreq_o), 1);
        chk("R2 code cleared", longint'(fail_code_o), 0);
        @(negedge clk);
        chk("R11 hreq single", longint'(hreq_o), 0);
        if (late_start) begin
            sec_i = 1'(s ^ 1); idx_i = 1'(e ^ 1);
            tgt_base_i = 8'h20; tgt_len_i = 8'd2;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        cyc = 0;
        while (!done_o && cyc < 300) begin
            @(negedge clk);
            cyc++;
        end
        chk("R6 done seen", longint'(done_o), 1);
        chk("R6 pass", longint'(pass_o), longint'(exp_code == 0));
        chk("R3 fail", longint'(fail_o), longint'(exp_code != 0));
        chk("R3 R4 R5 fail code", longint'(fail_code_o), longint'(exp_code));
        nreq = req_total - snap;
        chk("R7 request count", longint'(nreq), longint'(exp_code == 0 ? 3 : exp_code));
        if (nreq >= 1) begin
            chk("R2 R9 link1 base", longint'(req_base[snap & 1023]), longint'(tgt_b(s, e)));
            chk("R2 R9 link1 len", longint'(req_len[snap & 1023]), longint'(tgt_l(s, e)));
        end
        if (nreq >= 2) begin
            chk("R4 link2 base", longint'(req_base[(snap + 1) & 1023]), longint'(L2B + s * NE * WPD));
            chk("R4 link2 len", longint'(req_len[(snap + 1) & 1023]), longint'(NE * WPD));
        end
        if (nreq >= 3) begin
            chk("R5 link3 base", longint'(req_base[(snap + 2) & 1023]), longint'(L1B));
            chk("R5 link3 len", longint'(req_len[(snap + 2) & 1023]), longint'(NS * WPD));
        end
        @(negedge clk);
        chk("R6 done one cycle", longint'(done_o | pass_o | fail_o), 0);
        chk("R1 idle after run", longint'(busy_o), 0);
        repeat (3) @(negedge clk);
        chk("R10 code held", longint'(fail_code_o), longint'(exp_code));
    endtask

    initial begin : main
        for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 2));
        build_tables();
        repeat (3) @(negedge clk);
        chk("R1 busy reset", longint'(busy_o), 0);
        chk("R1 outputs reset", longint'({done_o, pass_o, fail_o, hreq_o}), 0);
        chk("R1 code reset", longint'(fail_code_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // full chain passes for every section/entry pair
        for (int s = 0; s < NS; s++)
            for (int e = 0; e < NE; e++) run(s, e, 0, 1'b0);

        // link 1 broken at each word position of the used entry
        for (int k = 0; k < WPD; k++) begin
            mem[l2_ent(1, 0) + k] ^= 8'(1 << k);
            run(1, 0, 1, 1'b0);
            mem[l2_ent(1, 0) + k] ^= 8'(1 << k);
        end

        // link 2 broken: sibling entry in the section, then first-tier word
        for (int k = 0; k < WPD; k++) begin
            mem[l2_ent(0, 0) + k] ^= 8'h80;
            run(0, 1, 2, 1'b0);
            mem[l2_ent(0, 0) + k] ^= 8'h80;
            mem[L1B + WPD + k] ^= 8'h01;
            run(1, 1, 2, 1'b0);
            mem[L1B + WPD + k] ^= 8'h01;
        end

        // link 3 broken at each anchor word
        for (int k = 0; k < WPD; k++) begin
            root_i[k*8 + 3] = ~root_i[k*8 + 3];
            run(0, 0, 3, 1'b0);
            root_i[k*8 + 3] = ~root_i[k*8 + 3];
        end

        // R9: start while busy is ignored
        run(1, 1, 0, 1'b1);
        run(0, 1, 0, 1'b1);

        // R8: stray response while idle
        stray_token++;
        repeat (4) @(negedge clk);
        chk("R8 idle stray keeps idle", longint'(busy_o | done_o), 0);
        chk("R8 idle stray keeps code", longint'(fail_code_o), 0);

        // R8: stray garbage response during comparison
        extra_mode = 1'b1;
        run(1, 0, 0, 1'b0);
        run(0, 0, 0, 1'b0);
        extra_mode = 1'b0;

        // R10 clear on new start after a failure
        root_i[0] = ~root_i[0];
        run(1, 1, 3, 1'b0);
        root_i[0] = ~root_i[0];
        run(1, 1, 0, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule